// File: doc/BRIEF.md
# Zero-skipping shift-add multiplier

This block multiplies two unsigned WIDTH-bit operands over WIDTH clock cycles and returns a 2*WIDTH-bit product. It handles one multiplier bit per cycle in the radix-2 way. It is arranged so that as few nodes as possible toggle while it works.

A one-hot sequencer walks across the multiplier bits, so the captured multiplier is never shifted. The captured multiplicand feeds one input of a ripple-carry adder directly, with no select logic in between. The upper partial product is held in two registers:

- A feeder register drives the adder's second input. It is loaded only when the coming multiplier bit is 1.
- A bypass register takes the partial product when the coming bit is 0. In that case the adder inputs stay unchanged through the zero cycle, and the result comes from the bypass register instead of the adder.

Each finalized low product bit is written once, in place, into the storage bit selected by the sequencer.

A user pulses start with the operands present, then waits for the one-cycle done pulse and reads the product.

Top module: `zsk_mult`

## Requirements
- R1: When done is high, product equals the unsigned product of the a_in and b_in values that were present in the cycle the run started. The product is zero-extended to 2*WIDTH bits.
- R2: A run starts at a rising clock edge where start is high and no run is active. done is then high for exactly one cycle, starting WIDTH rising edges after the starting edge.
- R3: While no run is active and start is low, product holds its value and done stays low after its pulse.
- R4: While a run is active, start, a_in and b_in are ignored. The result and the timing of done are those of the run already in progress.
- R5: After synchronous reset (rst high at a rising edge), product is all zeros and done is low.
- R6: A start given in the cycle where done is high is accepted as a new run, and that run obeys R1 and R2.
- R7: The ripple-carry adder's inputs do not change across any cycle whose multiplier bit is 0. This holds at the register level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with the present operands (ignored while busy) |
| a_in | input | WIDTH | Multiplicand |
| b_in | input | WIDTH | Multiplier |
| product | output | 2*WIDTH | Result; valid from done onward until the next start |
| done | output | 1 | One-cycle pulse marking a finished run |

## Verification
A sequencer pointer that skips or repeats a position shows up at the ports in two ways. done arrives too early or too late relative to the starting edge. In addition, one low product bit is left stale, which miscompares on the first operand pair where that bit is 1.

A wrong feeder or bypass routing decision corrupts the upper half on the first operand pair that has a 0 next to a 1 in the multiplier. That error is visible in the very done cycle of that run.

An operand register that is reloaded mid-run shows up in the result whenever the bench disturbs the inputs during a run.

// File: rtl/zsk_pkg.sv
package zsk_pkg;
   // where the next partial product is parked
   typedef enum logic {
      ROUTE_BYPASS = 1'b0,
      ROUTE_FEEDER = 1'b1
   } route_e;

   localparam int unsigned MIN_WIDTH = 2;
endpackage

// File: rtl/zsk_rca.sv
module zsk_rca #(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   output logic [WIDTH:0]   s
);
   logic [WIDTH:0] c;
   assign c[0] = 1'b0;

   for (genvar i = 0; i < WIDTH; i++) begin : g_fa
      assign s[i]   = x[i] ^ y[i] ^ c[i];
      assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
   end

   assign s[WIDTH] = c[WIDTH];
endmodule

// File: rtl/zsk_ring.sv
module zsk_ring #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   output logic [WIDTH-1:0] hot,
   output logic             busy,
   output logic             done
);
   always_ff @(posedge clk) begin
      if (rst) begin
         hot  <= '0;
         done <= 1'b0;
      end else begin
         done <= hot[WIDTH-1];
         if (load) hot <= {{(WIDTH-1){1'b0}}, 1'b1};
         else      hot <= {hot[WIDTH-2:0], 1'b0};
      end
   end

   assign busy = |hot;

   // R2
   ring_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(hot));
   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
endmodule

// File: rtl/zsk_lowbank.sv
module zsk_lowbank #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] en,
   input  logic             bit_in,
   output logic [WIDTH-1:0] q
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (rst)        q[i] <= 1'b0;
         else if (en[i]) q[i] <= bit_in;
      end
   end

   // R3
   low_hold_chk: assert property (@(posedge clk) disable iff (rst) (en == '0) |=> $stable(q));
endmodule

// File: rtl/zsk_mult.sv
module zsk_mult #(
   parameter int unsigned WIDTH = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic [WIDTH-1:0]   a_in,
   input  logic [WIDTH-1:0]   b_in,
   output logic [2*WIDTH-1:0] product,
   output logic               done
);
   import zsk_pkg::*;

   initial begin
      width_ok_chk: assert (WIDTH >= MIN_WIDTH) else $error("zsk_mult: WIDTH below minimum");
   end

   logic [WIDTH-1:0] a_q, b_q, feeder, bypass, hot, low_bits;
   logic [WIDTH:0]   add_out, sum;
   logic [WIDTH-1:0] pp_next;
   logic             busy, load, cur_bit, next_bit;
   route_e           route;

   assign load = start & ~busy;

   zsk_ring #(.WIDTH(WIDTH)) u_ring (
      .clk(clk), .rst(rst), .load(load), .hot(hot), .busy(busy), .done(done)
   );

   zsk_rca #(.WIDTH(WIDTH)) u_add (.x(a_q), .y(feeder), .s(add_out));

   assign cur_bit  = |(hot & b_q);
   assign next_bit = busy ? |({hot[WIDTH-2:0], 1'b0} & b_q) : b_in[0];
   assign route    = next_bit ? ROUTE_FEEDER : ROUTE_BYPASS;
   assign sum      = cur_bit ? add_out : {1'b0, bypass};
   assign pp_next  = load ? '0 : sum[WIDTH:1];

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q    <= '0;
         b_q    <= '0;
         feeder <= '0;
         bypass <= '0;
      end else begin
         if (load) begin
            a_q <= a_in;
            b_q <= b_in;
         end
         if (load || busy) begin
            if (route == ROUTE_FEEDER) feeder <= pp_next;
            else                       bypass <= pp_next;
         end
      end
   end

   zsk_lowbank #(.WIDTH(WIDTH)) u_low (
      .clk(clk), .rst(rst), .en(hot), .bit_in(sum[0]), .q(low_bits)
   );

   assign product = {bypass, low_bits};

   // R4
   opnd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      busy |=> ($stable(a_q) && $stable(b_q)));
   // R7
   feeder_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !next_bit) |=> $stable(feeder));
   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start) |=> $stable(product));
endmodule

// File: tb/zsk_mult_tb.sv
module zsk_mult_tb;
   localparam int unsigned W = 16;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           start = 1'b0;
   logic [W-1:0]   a_in = '0, b_in = '0;
   logic [2*W-1:0] product;
   logic           done;

   int n_chk = 0, n_bad = 0;
   logic [2*W-1:0] exp_q[$];
   logic [2*W-1:0] last_exp;

   always #10 clk = ~clk;

   zsk_mult #(.WIDTH(W)) u_dut (
      .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
      .product(product), .done(done)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // monitor: pops the scoreboard on each done
   always @(negedge clk) begin
      if (!rst && done) begin
         if (exp_q.size() == 0) check(1'b0, "R2 spurious done", 64'(done), 64'd0);
         else begin
            logic [2*W-1:0] e;
            e = exp_q.pop_front();
            check(product == e, "R1 product", 64'(product), 64'(e));
         end
      end
   end

   // driver: called at a negedge, returns one negedge later
   task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
      a_in  = a;
      b_in  = b;
      start = 1'b1;
      last_exp = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      exp_q.push_back(last_exp);
      @(negedge clk);
      start = 1'b0;
      a_in  = ~a;
      b_in  = ~b;
   endtask

   task automatic wait_done(input bit poke, input string req);
      int cyc = 1;
      while (!done && cyc < 500) begin
         @(negedge clk);
         cyc++;
         if (poke && cyc == 3) begin
            start = 1'b1;
            a_in  = 16'h1234;
            b_in  = 16'hBEEF;
         end
         if (poke && cyc == 4) start = 1'b0;
      end
      check(cyc == W + 1, req, 64'(cyc), 64'(W + 1));
   endtask

   task automatic run(input logic [W-1:0] a, input logic [W-1:0] b);
      launch(a, b);
      wait_done(1'b0, "R2 done timing");
      @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R5
      check(product == '0, "R5 reset product", 64'(product), 64'd0);
      check(done == 1'b0, "R5 reset done", 64'(done), 64'd0);

      // R1 corner cases
      run(16'h0000, 16'h0000);
      run(16'h0000, 16'hFFFF);
      run(16'hFFFF, 16'h0000);
      run(16'hFFFF, 16'hFFFF);
      run(16'h0001, 16'hABCD);
      run(16'hABCD, 16'h0001);
      run(16'h8000, 16'h8000);
      run(16'h8000, 16'h0001);
      run(16'hA5A5, 16'h5A5A);
      run(16'h5555, 16'hAAAA);

      // R3: idle hold after a run
      launch(16'hC3F1, 16'h7E09);
      wait_done(1'b0, "R2 done timing");
      repeat (4) begin
         @(negedge clk);
         check(product == last_exp, "R3 idle product", 64'(product), 64'(last_exp));
         check(done == 1'b0, "R3 idle done", 64'(done), 64'd0);
      end

      // R4: start and operand changes mid-run ignored
      launch(16'h0F0F, 16'h9001);
      wait_done(1'b1, "R4 done timing with poke");
      @(negedge clk);
      check(product == last_exp, "R4 result unaffected", 64'(product), 64'(last_exp));
      check(exp_q.size() == 0, "R4 no extra run", 64'(exp_q.size()), 64'd0);

      // R6: back-to-back start in the done cycle
      launch(16'h1357, 16'h2468);
      wait_done(1'b0, "R2 done timing");
      launch(16'hFEDC, 16'h0BA9);
      wait_done(1'b0, "R6 back-to-back timing");
      @(negedge clk);

      // R1 random pairs
      for (int i = 0; i < 40; i++) begin
         run(W'($urandom), W'($urandom));
      end

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R1 scoreboard drained", 64'(exp_q.size()), 64'd0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule